// File: doc/BRIEF.md
# Interrupt Pending and Gating Unit

This block keeps the eight pending-interrupt flags of a processor core and decides, every cycle, whether the core should take an interrupt. External agents set or drop single flags with post and clear requests, or drop them all at once. An on-chip timer is built from a free-running tick register and a match register. When the two are equal and the tick value is not zero, the block raises a pending flag at a position that software chooses.

The take decision is plain combinational logic on the current flags and on the core's status fields: a global enable, an exception-level flag, an error-level flag and an 8-bit mask. These status fields belong to the wider control-register file and enter as plain inputs. The mask and the pending field are each tested as a whole. An interrupt is taken when both are nonzero, even if they share no set bit. A small word-wide register port gives access to the tick, match and routing registers and a read-only view of the pending flags. Request and register pins are plain control pins with no handshake, because every request is absorbed in the cycle it is presented.

Top module: `irq_gate_unit`

## Requirements
- R1: A post with a valid line index n (0..7) sets pending bit n at the next clock edge and leaves every other pending bit unchanged.
- R2: A clear with a valid line index n clears pending bit n at the next clock edge and leaves every other pending bit unchanged.
- R3: A clear-all empties the pending field at the next clock edge and overrides any post, clear or timer set in that cycle. A clear and a post to the same line in the same cycle leave that bit at 0.
- R4: A post or clear whose 4-bit line index is 8 or more raises `req_err` in the same cycle and does not change the pending field.
- R5: `timer_match` is 1 exactly when the tick register equals the match register and the tick register is not zero.
- R6: While `timer_match` is 1, the pending bit selected by the routing field is set at the next clock edge. The routing field is bits [2:0] of register address 2.
- R7: `irq_pending` is 1 when any pending bit is set or `timer_match` is 1. The timer contribution shows in the same cycle, before it reaches the pending register.
- R8: `take_irq` is 0 whenever `st_ie` is 0, `st_erl` is 1 or `st_exl` is 1.
- R9: With `st_ie`=1, `st_erl`=0 and `st_exl`=0, `take_irq` is 1 exactly when `st_im` is nonzero and the pending field (with the timer bit folded in) is nonzero. No bitwise overlap of the two is required.
- R10: The register port decodes these addresses: address 0 is the tick register, 1 is the match register, 2 is the routing field, and 3 is the pending field (read-only, bits [7:0]). `reg_rdata` shows the addressed register in the same cycle. While `cnt_en` is 1, the tick register grows by one per cycle, and a write to address 0 in that cycle takes the written value instead.
- R11: A synchronous active-high reset clears the pending field, tick, match and routing registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Post request strobe |
| post_line | input | 4 | Line index for the post request |
| clr_valid | input | 1 | Clear request strobe |
| clr_line | input | 4 | Line index for the clear request |
| clr_all | input | 1 | Clear every pending bit |
| cnt_en | input | 1 | Tick register advance enable |
| reg_wr_en | input | 1 | Register port write strobe |
| reg_addr | input | 2 | Register port address |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data |
| st_ie | input | 1 | Global interrupt enable |
| st_exl | input | 1 | Exception-level flag |
| st_erl | input | 1 | Error-level flag |
| st_im | input | 8 | Interrupt mask field |
| req_err | output | 1 | Out-of-range line index on a request |
| timer_match | output | 1 | Timer match condition |
| irq_pending | output | 1 | Any interrupt pending |
| take_irq | output | 1 | Core should take an interrupt |

## Verification
A post and a clear can arrive in the same cycle, and a clear-all can land together with either. The bench drives a post and a clear to the same line on one edge, and a post beside a clear-all on another. It then reads the pending field through address 3 and expects the targeted bit to be 0. A timer set can also coincide with a register write that removes the match. In that case the bench expects the routed bit to be set on that edge, because the match was still true before the write landed.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  typedef enum logic [1:0] {
    RA_TICK  = 2'd0,
    RA_MATCH = 2'd1,
    RA_ROUTE = 2'd2,
    RA_PEND  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
  import irq_gate_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic [NLINES-1:0] pend_q,
  output logic [CNT_W-1:0]  rdata,
  output logic [CNT_W-1:0]  tick_q,
  output logic [CNT_W-1:0]  match_q,
  output logic [IDX_W-1:0]  route_q
);
  logic wr_tick, wr_match, wr_route;

  always_comb begin
    wr_tick  = wr_en && (addr == RA_TICK);
    wr_match = wr_en && (addr == RA_MATCH);
    wr_route = wr_en && (addr == RA_ROUTE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
    end else if (wr_tick) begin
      tick_q <= wdata;
    end else if (cnt_en) begin
      tick_q <= tick_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
    end else if (wr_match) begin
      match_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= '0;
    end else if (wr_route) begin
      route_q <= wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    unique case (addr)
      RA_TICK:  rdata = tick_q;
      RA_MATCH: rdata = match_q;
      RA_ROUTE: rdata = CNT_W'(route_q);
      default:  rdata = CNT_W'(pend_q);
    endcase
  end

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !wr_tick) |=> (tick_q == $past(tick_q) + CNT_W'(1))); // R10

  AST_TICK_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_tick |=> (tick_q == $past(wdata))); // R10
endmodule

// File: rtl/irq_timer_match.sv
module irq_timer_match #(
  parameter int CNT_W  = 32,
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  tick_q,
  input  logic [CNT_W-1:0]  match_q,
  input  logic [IDX_W-1:0]  route_q,
  output logic              hit,
  output logic [NLINES-1:0] route_mask
);
  always_comb begin
    hit = (tick_q == match_q) && (tick_q != '0);
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_route
    assign route_mask[i] = hit && (route_q == IDX_W'(i));
  end

  AST_ZERO_TICK_QUIET: assert property (@(posedge clk) disable iff (rst)
    (tick_q == '0) |-> (route_mask == '0)); // R5

  AST_ROUTE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    hit |-> $onehot(route_mask)); // R6
endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
  parameter int NLINES = 8,
  localparam int IDX_W  = $clog2(NLINES),
  localparam int LINE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_valid,
  input  logic [LINE_W-1:0] post_line,
  input  logic              clr_valid,
  input  logic [LINE_W-1:0] clr_line,
  input  logic              clr_all,
  input  logic [NLINES-1:0] tmr_mask,
  output logic [NLINES-1:0] pend_q,
  output logic              bad_idx
);
  logic post_bad, clr_bad;
  logic [NLINES-1:0] post_hit, clr_hit;

  always_comb begin
    post_bad = post_valid && (post_line >= LINE_W'(NLINES));
    clr_bad  = clr_valid  && (clr_line  >= LINE_W'(NLINES));
    bad_idx  = post_bad || clr_bad;
  end

  for (genvar i = 0; i < NLINES; i++) begin : g_bit
    assign post_hit[i] = post_valid && (post_line == LINE_W'(i));
    assign clr_hit[i]  = clr_valid  && (clr_line  == LINE_W'(i));

    always_ff @(posedge clk) begin
      if (rst) begin
        pend_q[i] <= 1'b0;
      end else if (clr_all) begin
        pend_q[i] <= 1'b0;
      end else if (clr_hit[i]) begin
        pend_q[i] <= 1'b0;
      end else if (post_hit[i] || tmr_mask[i]) begin
        pend_q[i] <= 1'b1;
      end
    end
  end

  AST_CLR_ALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (pend_q == '0)); // R3

  AST_BAD_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bad_idx && !clr_all && (tmr_mask == '0) && !(post_valid && !post_bad)
     && !(clr_valid && !clr_bad)) |=> (pend_q == $past(pend_q))); // R4

  AST_POST_SETS: assert property (@(posedge clk) disable iff (rst)
    (!clr_all && !clr_valid && !post_bad && post_valid)
    |=> ((pend_q & $past(post_hit)) == $past(post_hit))); // R1

  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (clr_valid && !clr_bad) |=> ((pend_q & $past(clr_hit)) == '0)); // R2
endmodule

// File: rtl/irq_take_logic.sv
module irq_take_logic #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLINES-1:0] pend_q,
  input  logic [NLINES-1:0] tmr_mask,
  input  logic              st_ie,
  input  logic              st_exl,
  input  logic              st_erl,
  input  logic [NLINES-1:0] st_im,
  output logic              any_pend,
  output logic              take
);
  logic [NLINES-1:0] eff_pend;
  logic gate_open;

  always_comb begin
    eff_pend  = pend_q | tmr_mask;
    any_pend  = |eff_pend;
    gate_open = st_ie && !st_erl && !st_exl;
    take      = gate_open && (|st_im) && any_pend;
  end

  AST_TAKE_GATED: assert property (@(posedge clk) disable iff (rst)
    take |-> (st_ie && !st_erl && !st_exl)); // R8

  AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    take |-> ((pend_q != '0) || (tmr_mask != '0))); // R9
endmodule

// File: rtl/irq_gate_unit.sv
module irq_gate_unit #(
  parameter int CNT_W  = 32,
  parameter int NLINES = 8,
  localparam int IDX_W  = $clog2(NLINES),
  localparam int LINE_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              post_valid,
  input  logic [LINE_W-1:0] post_line,
  input  logic              clr_valid,
  input  logic [LINE_W-1:0] clr_line,
  input  logic              clr_all,
  input  logic              cnt_en,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic [CNT_W-1:0]  reg_rdata,
  input  logic              st_ie,
  input  logic              st_exl,
  input  logic              st_erl,
  input  logic [NLINES-1:0] st_im,
  output logic              req_err,
  output logic              timer_match,
  output logic              irq_pending,
  output logic              take_irq
);
  logic [NLINES-1:0] pend_q, tmr_mask;
  logic [CNT_W-1:0]  tick_q, match_q;
  logic [IDX_W-1:0]  route_q;

  irq_ctl_regs #(.CNT_W(CNT_W), .NLINES(NLINES)) u_regs (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(reg_wr_en),
    .addr(reg_addr), .wdata(reg_wdata), .pend_q(pend_q),
    .rdata(reg_rdata), .tick_q(tick_q), .match_q(match_q),
    .route_q(route_q)
  );

  irq_timer_match #(.CNT_W(CNT_W), .NLINES(NLINES)) u_timer (
    .clk(clk), .rst(rst), .tick_q(tick_q), .match_q(match_q),
    .route_q(route_q), .hit(timer_match), .route_mask(tmr_mask)
  );

  irq_pending_reg #(.NLINES(NLINES)) u_pend (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_line(post_line),
    .clr_valid(clr_valid), .clr_line(clr_line), .clr_all(clr_all),
    .tmr_mask(tmr_mask), .pend_q(pend_q), .bad_idx(req_err)
  );

  irq_take_logic #(.NLINES(NLINES)) u_take (
    .clk(clk), .rst(rst), .pend_q(pend_q), .tmr_mask(tmr_mask),
    .st_ie(st_ie), .st_exl(st_exl), .st_erl(st_erl), .st_im(st_im),
    .any_pend(irq_pending), .take(take_irq)
  );

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (pend_q == '0 && tick_q == '0 && match_q == '0)); // R11
endmodule

// File: tb/irq_gate_unit_tb.sv
module irq_gate_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic post_valid = 0, clr_valid = 0, clr_all = 0, cnt_en = 0, reg_wr_en = 0;
  logic [3:0] post_line = 0, clr_line = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic st_ie = 0, st_exl = 0, st_erl = 0;
  logic [7:0] st_im = 0;
  logic req_err, timer_match, irq_pending, take_irq;
  int n_checks = 0;
  int n_errs = 0;

  always #2 clk = ~clk;

  irq_gate_unit u_dut (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_line(post_line),
    .clr_valid(clr_valid), .clr_line(clr_line), .clr_all(clr_all),
    .cnt_en(cnt_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .st_ie(st_ie),
    .st_exl(st_exl), .st_erl(st_erl), .st_im(st_im), .req_err(req_err),
    .timer_match(timer_match), .irq_pending(irq_pending), .take_irq(take_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr_en = 0;
  endtask

  task automatic post(input logic [3:0] ln);
    @(negedge clk);
    post_valid = 1; post_line = ln;
    tick();
    post_valid = 0;
  endtask

  task automatic clear(input logic [3:0] ln);
    @(negedge clk);
    clr_valid = 1; clr_line = ln;
    tick();
    clr_valid = 0;
  endtask

  task automatic wipe();
    @(negedge clk);
    clr_all = 1;
    tick();
    clr_all = 0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      read_reg(2'(a), v);
      check("R11 reset reg", v, 0);
    end
    check("R11 reset pending", {31'd0, irq_pending}, 0);
  endtask

  task automatic t_post_clear();
    logic [31:0] v;
    post(4'd3);
    read_reg(2'd3, v); check("R1 post 3", v, 32'h08);
    post(4'd5);
    read_reg(2'd3, v); check("R1 post 5 keeps 3", v, 32'h28);
    post(4'd0);
    read_reg(2'd3, v); check("R1 post 0", v, 32'h29);
    clear(4'd3);
    read_reg(2'd3, v); check("R2 clear 3", v, 32'h21);
    wipe();
    read_reg(2'd3, v); check("R3 clear-all", v, 32'h00);
  endtask

  task automatic t_bad_index();
    logic [31:0] v;
    post(4'd2);
    @(negedge clk);
    post_valid = 1; post_line = 4'd9;
    #1 check("R4 req_err on post 9", {31'd0, req_err}, 1);
    tick();
    post_valid = 0;
    read_reg(2'd3, v); check("R4 post 9 no change", v, 32'h04);
    @(negedge clk);
    clr_valid = 1; clr_line = 4'd12;
    #1 check("R4 req_err on clear 12", {31'd0, req_err}, 1);
    tick();
    clr_valid = 0;
    read_reg(2'd3, v); check("R4 clear 12 no change", v, 32'h04);
    check("R4 req_err idle", {31'd0, req_err}, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    @(negedge clk);
    post_valid = 1; post_line = 4'd2; clr_valid = 1; clr_line = 4'd2;
    tick();
    post_valid = 0; clr_valid = 0;
    read_reg(2'd3, v); check("R3 clear beats post", v, 32'h00);
    post(4'd7);
    @(negedge clk);
    post_valid = 1; post_line = 4'd1; clr_all = 1;
    tick();
    post_valid = 0; clr_all = 0;
    read_reg(2'd3, v); check("R3 clear-all beats post", v, 32'h00);
  endtask

  task automatic t_timer();
    logic [31:0] v;
    write_reg(2'd2, 32'd6);
    read_reg(2'd2, v); check("R10 route readback", v, 6);
    write_reg(2'd1, 32'd5);
    write_reg(2'd0, 32'd5);
    check("R5 match equal nonzero", {31'd0, timer_match}, 1);
    read_reg(2'd3, v); check("R7 pend reg not yet set", v, 0);
    check("R7 folded pending", {31'd0, irq_pending}, 1);
    tick();
    read_reg(2'd3, v); check("R6 routed bit 6", v, 32'h40);
    write_reg(2'd1, 32'd9);
    check("R5 no match after compare change", {31'd0, timer_match}, 0);
    wipe();
    read_reg(2'd3, v); check("R6 cleared", v, 0);
    write_reg(2'd0, 32'd0);
    write_reg(2'd1, 32'd0);
    check("R5 zero tick no match", {31'd0, timer_match}, 0);
    check("R7 nothing pending", {31'd0, irq_pending}, 0);
  endtask

  task automatic t_gate();
    post(4'd1);
    @(negedge clk);
    st_ie = 1; st_im = 8'h04; st_exl = 0; st_erl = 0;
    #1 check("R9 take without overlap", {31'd0, take_irq}, 1);
    st_im = 8'h00;
    #1 check("R9 mask zero", {31'd0, take_irq}, 0);
    st_im = 8'h80; st_exl = 1;
    #1 check("R8 exl blocks", {31'd0, take_irq}, 0);
    st_exl = 0; st_erl = 1;
    #1 check("R8 erl blocks", {31'd0, take_irq}, 0);
    st_erl = 0; st_ie = 0;
    #1 check("R8 ie low blocks", {31'd0, take_irq}, 0);
    st_ie = 1;
    #1 check("R9 gate open", {31'd0, take_irq}, 1);
    wipe();
    check("R9 no pending no take", {31'd0, take_irq}, 0);
    st_ie = 0; st_im = 0;
  endtask

  task automatic t_count();
    logic [31:0] v;
    write_reg(2'd0, 32'd10);
    @(negedge clk);
    cnt_en = 1;
    repeat (4) @(posedge clk);
    #1 cnt_en = 0;
    read_reg(2'd0, v); check("R10 four steps", v, 14);
    @(negedge clk);
    cnt_en = 1; reg_wr_en = 1; reg_addr = 2'd0; reg_wdata = 32'd100;
    tick();
    reg_wr_en = 0; cnt_en = 0;
    read_reg(2'd0, v); check("R10 write wins over step", v, 100);
    read_reg(2'd1, v); check("R10 match readback", v, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    t_reset();
    t_post_clear();
    t_bad_index();
    t_collide();
    t_timer();
    t_gate();
    t_count();
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    #200000;
    n_checks++;
    n_errs++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule